// File: doc/BRIEF.md
# Delayed-Transaction Retry Command Matcher

A bridge that holds a delayed (non-posted) transaction has to decide, each time an initiator repeats a cycle, whether that repeat is the same transaction it has already queued. This block makes that decision. It takes the stored command, the stored originating side, the retried command, the retry's side and an address-hit flag from the address decoder. It raises a match flag when the two cycles are the same transaction. Command equality can be relaxed for each side by programmable alias rules. Under these rules, a line or multiple read may stand in for a plain memory read, line and multiple reads may stand in for each other, and, on the secondary side, a write-and-invalidate may stand in for a plain memory write.

The block also chooses the command that goes out on the destination interface when a write-and-invalidate is accepted. By default that command is downgraded to a plain memory write. A disable bit for each side makes the block forward it unchanged. All controls sit in one 16-bit register, written with byte enables and read back in full. Both outputs are combinational from the registered controls.

Top module: `dtm_retry_matcher`

## Requirements
- R1: After reset the control register reads 0x006C: bits 2, 3, 5 and 6 are set, and every other bit is 0. Bits outside 2..8 always read 0.
- R2: A write takes effect at the rising clock edge while `cfg_wr` is high. Byte enable 0 updates bits 7:0, byte enable 1 updates bits 15:8, and a lane whose enable is low keeps its value.
- R3: `retry_match` is 1 only when `addr_hit` is 1 and `retry_side` equals `stored_side`. With equal commands, both conditions together give a match. Side encoding: 0 is primary, 1 is secondary.
- R4: Read alias: for a stored memory read (0110), a retried read-multiple (1100) or read-line (1110) matches when the read-alias bit of the retry's side is 1 (bit 2 primary, bit 3 secondary). It does not match when that bit is 0. A stored line or multiple read is never matched by a retried plain read.
- R5: Line/multiple alias: read-line and read-multiple match each other in either direction when the alias bit of the retry's side is 1 (bit 5 primary, bit 6 secondary). They do not match when that bit is 0.
- R6: Write alias: on the secondary side, a retried write-and-invalidate (1111) matches a stored memory write (0111) when bit 4 is 1. On the primary side this pair never matches. A retried memory write never matches a stored write-and-invalidate.
- R7: Commands other than the five memory commands (for example I/O read 0010 and I/O write 0011) match only when they are exactly equal, whatever the alias bits are.
- R8: `fwd_cmd_out` equals `fwd_cmd_in`, except for one case. An input of 1111 becomes 0111 when the conversion-disable bit of `fwd_side` is 0 (bit 7 primary, bit 8 secondary).
- R9: A control write changes `retry_match` and `fwd_cmd_out` starting in the cycle after the write edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Control register contents |
| stored_cmd | input | 4 | Command of the queued delayed transaction |
| stored_side | input | 1 | Side the queued transaction came from |
| retry_cmd | input | 4 | Command of the retried cycle |
| retry_side | input | 1 | Side the retried cycle arrived on |
| addr_hit | input | 1 | Address comparison result |
| retry_match | output | 1 | Retry is the queued transaction |
| fwd_side | input | 1 | Side that accepted the command to forward |
| fwd_cmd_in | input | 4 | Accepted command |
| fwd_cmd_out | output | 4 | Command issued on the destination |

## Verification
The only state in the block is the control register, so a wrong internal state is a wrong control bit. That bit is visible at once on `cfg_rdata`. It also shows as a match or a miss on the first retry pair that uses its alias rule, or as a wrong downgrade on the next forwarded write-and-invalidate. Each alias pair is therefore tested with its controlling bit set and with it cleared, on both sides. The point at which a new value takes effect is checked one cycle on either side of the write edge.

// File: rtl/dtm_pkg.sv
// Shared command codes and control-bit positions for the retry matcher.
package dtm_pkg;
    localparam logic [3:0] CMD_MR  = 4'b0110;
    localparam logic [3:0] CMD_MW  = 4'b0111;
    localparam logic [3:0] CMD_MRM = 4'b1100;
    localparam logic [3:0] CMD_MRL = 4'b1110;
    localparam logic [3:0] CMD_MWI = 4'b1111;

    localparam int CMD_W    = 4;
    localparam int NSIDE    = 2;
    localparam int BIT_RDA  = 2;   // + side
    localparam int BIT_WRA  = 4;   // secondary only
    localparam int BIT_LMA  = 5;   // + side
    localparam int BIT_KEEP = 7;   // + side

    // True for one of the memory read commands that aliasing touches.
    function automatic logic is_burst_read(input logic [3:0] c);
        return (c == CMD_MRM) || (c == CMD_MRL);
    endfunction
endpackage

// File: rtl/dtm_ctrl_reg.sv
// Control register with byte-lane writes.
// Assumes: DATA_W is a multiple of 8; bits outside IMPL_MASK read as 0.
module dtm_ctrl_reg #(
    parameter int          DATA_W    = 16,
    parameter logic [15:0] IMPL_MASK = 16'h01FC,
    parameter logic [15:0] RST_VAL   = 16'h006C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   q
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Load defaults on reset, else take the lane's masked write data.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g*8 +: 8] <= RST_VAL[g*8 +: 8];
            else if (wr && be[g])
                q[g*8 +: 8] <= wdata[g*8 +: 8] & IMPL_MASK[g*8 +: 8];
        end
    end

    p_reset_value_r1: assert property (@(posedge clk) !rst_n |=> q == RST_VAL)
        else $error("control register not at default after reset");
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q))
        else $error("control register changed without a write");
    p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~IMPL_MASK) == '0)
        else $error("unimplemented control bit set");
endmodule

// File: rtl/dtm_cmd_equiv.sv
// Decides whether a retried command equals a stored one under one side's
// alias controls. Assumes the caller has already qualified side and address.
module dtm_cmd_equiv
    import dtm_pkg::*;
(
    input  logic [CMD_W-1:0] stored,
    input  logic [CMD_W-1:0] retry,
    input  logic             rd_alias,
    input  logic             wr_alias,
    input  logic             lm_alias,
    output logic             equiv
);
    // Exact equality, or one of the enabled directional alias pairs.
    always_comb begin
        equiv = (stored == retry);
        if (rd_alias && stored == CMD_MR && is_burst_read(retry))
            equiv = 1'b1;
        if (lm_alias && is_burst_read(stored) && is_burst_read(retry))
            equiv = 1'b1;
        if (wr_alias && stored == CMD_MW && retry == CMD_MWI)
            equiv = 1'b1;
    end
endmodule

// File: rtl/dtm_fwd_xlate.sv
// Picks the destination command for an accepted command: a
// write-and-invalidate is downgraded to a memory write unless kept.
module dtm_fwd_xlate
    import dtm_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_in,
    input  logic             keep_mwi,
    output logic [CMD_W-1:0] cmd_out
);
    // Downgrade only the write-and-invalidate code.
    always_comb begin
        cmd_out = cmd_in;
        if (cmd_in == CMD_MWI && !keep_mwi)
            cmd_out = CMD_MW;
    end
endmodule

// File: rtl/dtm_retry_matcher.sv
// Delayed-transaction retry matcher: registered alias controls, one
// equivalence check per side, and the forwarding command translator.
// Assumes side 0 is primary and side 1 is secondary.
module dtm_retry_matcher
    import dtm_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_W/8-1:0] cfg_be,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [CMD_W-1:0]   stored_cmd,
    input  logic               stored_side,
    input  logic [CMD_W-1:0]   retry_cmd,
    input  logic               retry_side,
    input  logic               addr_hit,
    output logic               retry_match,
    input  logic               fwd_side,
    input  logic [CMD_W-1:0]   fwd_cmd_in,
    output logic [CMD_W-1:0]   fwd_cmd_out
);
    logic [CFG_W-1:0] ctrl;
    logic [NSIDE-1:0] eq_side;
    logic [NSIDE-1:0] wr_alias;

    dtm_ctrl_reg #(.DATA_W(CFG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .be(cfg_be),
        .wdata(cfg_wdata), .q(ctrl)
    );

    assign cfg_rdata = ctrl;
    assign wr_alias  = {ctrl[BIT_WRA], 1'b0};

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dtm_cmd_equiv u_eq (
            .stored(stored_cmd), .retry(retry_cmd),
            .rd_alias(ctrl[BIT_RDA + s]), .wr_alias(wr_alias[s]),
            .lm_alias(ctrl[BIT_LMA + s]), .equiv(eq_side[s])
        );
    end

    // Qualify command equivalence by address and by originating side.
    always_comb begin
        retry_match = addr_hit && (stored_side == retry_side) && eq_side[retry_side];
    end

    dtm_fwd_xlate u_xlate (
        .cmd_in(fwd_cmd_in), .keep_mwi(ctrl[BIT_KEEP + fwd_side]),
        .cmd_out(fwd_cmd_out)
    );

    p_hit_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> !retry_match) else $error("match without address hit");
    p_side_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stored_side != retry_side) |-> !retry_match) else $error("match across sides");
    p_nonmem_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_match && !is_burst_read(retry_cmd) && retry_cmd != CMD_MWI)
            |-> retry_cmd == stored_cmd) else $error("non-aliased command matched inexactly");
    p_primary_no_walias_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_side == 1'b0 && retry_cmd == CMD_MWI && stored_cmd == CMD_MW)
            |-> !retry_match) else $error("primary write alias");
    p_xlate_only_mwi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_cmd_out != fwd_cmd_in) |-> (fwd_cmd_in == CMD_MWI && fwd_cmd_out == CMD_MW))
        else $error("translator changed a non-MWI command");
endmodule

// File: tb/dtm_retry_matcher_tb.sv
module dtm_retry_matcher_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  stored_cmd = '0, retry_cmd = '0, fwd_cmd_in = '0, fwd_cmd_out;
    logic        stored_side = 1'b0, retry_side = 1'b0, addr_hit = 1'b0, fwd_side = 1'b0;
    logic        retry_match;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [3:0] MR = 4'b0110, MW = 4'b0111, MRM = 4'b1100,
                           MRL = 4'b1110, MWI = 4'b1111, IOR = 4'b0010, IOW = 4'b0011;

    always #10 clk = ~clk;

    dtm_retry_matcher u_dut (.*);

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic try_match(string req, logic ss, logic [3:0] sc, logic rs,
                             logic [3:0] rc, logic hit, logic exp);
        stored_side = ss; stored_cmd = sc; retry_side = rs; retry_cmd = rc; addr_hit = hit;
        #1;
        check(req, {15'b0, retry_match}, {15'b0, exp});
    endtask

    task automatic t_reset();
        check("R1 reset value", cfg_rdata, 16'h006C);
    endtask

    task automatic t_bytewrite();
        cfg_write(2'b10, 16'hFFFF);
        #1 check("R2 upper lane only", cfg_rdata, 16'h016C);
        cfg_write(2'b01, 16'h0000);
        #1 check("R2 lower lane only", cfg_rdata, 16'h0100);
        cfg_write(2'b11, 16'hFFFF);
        #1 check("R1 unimplemented bits zero", cfg_rdata, 16'h01FC);
        cfg_write(2'b11, 16'h006C);
    endtask

    task automatic t_exact();
        try_match("R3 exact match", 0, MW, 0, MW, 1, 1);
        try_match("R3 no addr hit", 0, MW, 0, MW, 0, 0);
        try_match("R3 side differs", 0, MW, 1, MW, 1, 0);
        try_match("R3 secondary exact", 1, MRL, 1, MRL, 1, 1);
    endtask

    task automatic t_read_alias();
        try_match("R4 pri MRM to MR", 0, MR, 0, MRM, 1, 1);
        try_match("R4 sec MRL to MR", 1, MR, 1, MRL, 1, 1);
        try_match("R4 reverse never", 0, MRL, 0, MR, 1, 0);
        cfg_write(2'b01, 16'h0068);   // clear bit 2
        try_match("R4 pri alias off", 0, MR, 0, MRM, 1, 0);
        try_match("R4 sec alias still on", 1, MR, 1, MRM, 1, 1);
        cfg_write(2'b01, 16'h0064);   // clear bit 3 only
        try_match("R4 sec alias off", 1, MR, 1, MRL, 1, 0);
        try_match("R4 pri alias on again", 0, MR, 0, MRL, 1, 1);
        cfg_write(2'b11, 16'h006C);
    endtask

    task automatic t_lm_alias();
        try_match("R5 pri MRL to MRM", 0, MRM, 0, MRL, 1, 1);
        try_match("R5 sec MRM to MRL", 1, MRL, 1, MRM, 1, 1);
        cfg_write(2'b01, 16'h004C);   // clear bit 5
        try_match("R5 pri alias off", 0, MRM, 0, MRL, 1, 0);
        try_match("R5 sec alias on", 1, MRM, 1, MRL, 1, 1);
        cfg_write(2'b01, 16'h002C);   // clear bit 6 only
        try_match("R5 sec alias off", 1, MRL, 1, MRM, 1, 0);
        cfg_write(2'b11, 16'h006C);
    endtask

    task automatic t_write_alias();
        try_match("R6 sec default off", 1, MW, 1, MWI, 1, 0);
        cfg_write(2'b01, 16'h007C);   // set bit 4
        try_match("R6 sec alias on", 1, MW, 1, MWI, 1, 1);
        try_match("R6 primary never", 0, MW, 0, MWI, 1, 0);
        try_match("R6 reverse never", 1, MWI, 1, MW, 1, 0);
    endtask

    task automatic t_nonmem();
        cfg_write(2'b11, 16'h01FC);
        try_match("R7 IO exact", 1, IOR, 1, IOR, 1, 1);
        try_match("R7 IO inexact", 1, IOR, 1, IOW, 1, 0);
        try_match("R7 MR vs MW", 0, MR, 0, MW, 1, 0);
        cfg_write(2'b11, 16'h006C);
    endtask

    task automatic t_xlate();
        fwd_side = 0; fwd_cmd_in = MWI; #1 check("R8 pri downgrade", {12'b0, fwd_cmd_out}, {12'b0, MW});
        fwd_side = 1; #1 check("R8 sec downgrade", {12'b0, fwd_cmd_out}, {12'b0, MW});
        fwd_cmd_in = MRL; #1 check("R8 other passes", {12'b0, fwd_cmd_out}, {12'b0, MRL});
        cfg_write(2'b10, 16'h0100);   // bit 8
        fwd_cmd_in = MWI; #1 check("R8 sec kept", {12'b0, fwd_cmd_out}, {12'b0, MWI});
        fwd_side = 0; #1 check("R8 pri still downgrades", {12'b0, fwd_cmd_out}, {12'b0, MW});
        cfg_write(2'b11, 16'h00EC);   // bit 7 only
        #1 check("R8 pri kept", {12'b0, fwd_cmd_out}, {12'b0, MWI});
        cfg_write(2'b11, 16'h006C);
    endtask

    task automatic t_latency();
        @(negedge clk);
        try_match("R9 before write", 1, MR, 1, MRL, 1, 1);
        cfg_wr = 1'b1; cfg_be = 2'b01; cfg_wdata = 16'h0064;
        @(posedge clk); #1;
        check("R9 after edge", {15'b0, retry_match}, 16'h0000);
        @(negedge clk); cfg_wr = 1'b0; cfg_be = '0;
        cfg_write(2'b11, 16'h006C);
        #1 check("R9 restored", {15'b0, retry_match}, 16'h0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        t_reset();
        t_bytewrite();
        t_exact();
        t_read_alias();
        t_lm_alias();
        t_write_alias();
        t_nonmem();
        t_xlate();
        t_latency();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule